// File: doc/BRIEF.md
# Branch Condition and Target Resolver

This unit decides whether a decoded branch is taken and where it goes. It also owns the 64-bit link and count registers that branches read and update. The decoder supplies six things: a two-bit form code, a five-bit rule field, a five-bit condition-bit selector, an immediate displacement, an absolute-address flag and a link flag. The unit also receives the current instruction address and the 32-bit condition register.

In the same cycle the unit returns three results: the taken decision, the resolved target and an illegal-form flag. At the next clock edge it writes the link and count registers. Other execution units can load either register through a load port, and a branch update wins over a load of the same register in the same cycle.

The rule field combines three tests. The first is an optional decrement of the count register. The second tests whether the count is zero or non-zero. The third compares a selected condition bit against a required value. Targets come from a long displacement, a short displacement, the link register or the count register.

Top module: `brx_resolve`

## Requirements
- R1: Selector value k tests condition register bit cr[31-k], so selector 0 picks the most significant bit.
- R2: Rule bits are read MSB first. Bit 4 set ignores the condition bit, and bit 3 is the required condition value. Bit 2 set suppresses the count decrement. Bit 1 set passes the count test on zero, and clear passes it on non-zero. Bit 0 has no effect. A branch is taken when both the count test and the condition test pass.
- R3: Any rule of the form 1z1zz is always taken and leaves the count register unchanged.
- R4: Form 0 is always taken, whatever the rule field, and never decrements the count. Its target comes from the 24-bit displacement shifted left by two. Relative mode sign-extends that value and adds it to the current address. Absolute mode zero-extends it and uses it directly as the target.
- R5: Form 1 follows the rule field. Its target comes from the low 14 bits of the displacement shifted left by two. Relative mode sign-extends and adds; absolute mode zero-extends.
- R6: When a decrement is requested, the count test uses the decremented value. The count register then holds that value modulo 2^64, so a count of zero becomes all ones.
- R7: A valid, legal branch with the link flag set writes current address + 4 into the link register, whether or not it is taken.
- R8: Form 2 targets the link register and form 3 targets the count register, each with its two low bits cleared. Form 2 reads the link value from before any link update by the same branch.
- R9: Form 3 with the decrement requested (rule bit 2 clear) raises illegal. In that case taken is 0, the target is 0, and neither register changes.
- R10: A load-port write appears on the register at the next edge. When a branch updates the same register in the same cycle, the branch value is kept.
- R11: After reset both registers read 0. While no branch is valid, taken, illegal and target are 0 and the registers change only through the load port.
- R12: Taken, target and illegal follow the inputs in the same cycle. The register updates appear only after the next rising edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| br_valid | input | 1 | A decoded branch is present |
| br_form | input | 2 | 0 long immediate, 1 short immediate, 2 via link, 3 via count |
| br_rule | input | 5 | Condition and count rule |
| br_sel | input | 5 | Condition bit selector |
| br_disp | input | 24 | Displacement; form 1 uses the low 14 bits |
| br_abs | input | 1 | Displacement is an absolute address |
| br_link | input | 1 | Save the return address in the link register |
| cia | input | 64 | Current instruction address |
| cr | input | 32 | Condition register |
| lr_ld_en | input | 1 | Load link register |
| lr_ld_data | input | 64 | Link register load value |
| ctr_ld_en | input | 1 | Load count register |
| ctr_ld_data | input | 64 | Count register load value |
| taken | output | 1 | Branch is taken |
| target | output | 64 | Resolved target address |
| illegal | output | 1 | Illegal form detected |
| lr_q | output | 64 | Link register |
| ctr_q | output | 64 | Count register |

## Verification
The checks that run on every cycle cover several properties. Form 0 is always taken, and an illegal form stays quiet and leaves both registers alone. A requested decrement reduces the count by exactly one, while rules that suppress the decrement leave the count untouched. A linked branch stores the return address, register targets are aligned, and nothing is taken or flagged while idle.

Other behaviour only the bench scenarios can show, because it needs known operand values. This covers the exact target arithmetic, including negative displacements and zero-extended absolute values. It also covers the mapping from selector to condition bit, each rule pattern's decision, the wrap of a zero count, and the read of the old link value. Finally, only the scenarios can confirm that a branch wins over a same-cycle load.

// File: rtl/brx_pkg.sv
package brx_pkg;
   typedef enum logic [1:0] {
      FORM_IMM_LONG  = 2'd0,
      FORM_IMM_SHORT = 2'd1,
      FORM_VIA_LINK  = 2'd2,
      FORM_VIA_COUNT = 2'd3
   } brx_form_e;

   localparam int RULE_W      = 5;
   localparam int RB_IGN_COND = 4;
   localparam int RB_COND_VAL = 3;
   localparam int RB_NO_DEC   = 2;
   localparam int RB_ON_ZERO  = 1;
endpackage

// File: rtl/brx_decide.sv
module brx_decide
   import brx_pkg::*;
#(
   parameter int AW  = 64,
   parameter int CRW = 32,
   localparam int SEL_W = $clog2(CRW)
) (
   input  brx_form_e          form,
   input  logic [RULE_W-1:1]  rule,
   input  logic [SEL_W-1:0]   sel,
   input  logic [CRW-1:0]     cr,
   input  logic [AW-1:0]      ctr_cur,
   output logic               take_ok,
   output logic               dec_req,
   output logic [AW-1:0]      ctr_next
);
   logic [CRW-1:0] cr_rev;
   logic [AW-1:0]  ctr_view;
   logic           cond_bit, ctr_ok, cond_ok;

   // selector 0 addresses the most significant condition bit
   for (genvar i = 0; i < CRW; i++) begin : g_rev
      assign cr_rev[i] = cr[CRW-1-i];
   end

   always_comb begin
      cond_bit = cr_rev[sel];
      dec_req  = (form != FORM_IMM_LONG) && !rule[RB_NO_DEC];
      ctr_next = ctr_cur - AW'(1);
      ctr_view = dec_req ? ctr_next : ctr_cur;
      ctr_ok   = rule[RB_NO_DEC] | ((ctr_view == '0) == rule[RB_ON_ZERO]);
      cond_ok  = rule[RB_IGN_COND] | (cond_bit == rule[RB_COND_VAL]);
      take_ok  = (form == FORM_IMM_LONG) | (ctr_ok & cond_ok);
   end
endmodule

// File: rtl/brx_imm_ext.sv
module brx_imm_ext #(
   parameter int AW         = 64,
   parameter int DW         = 24,
   parameter int ALIGN      = 2,
   parameter bit ABS_SIGNED = 1'b0,
   localparam int EW = DW + ALIGN
) (
   input  logic [DW-1:0] disp,
   input  logic          abs_mode,
   input  logic [AW-1:0] cia,
   output logic [AW-1:0] addr
);
   logic [AW-1:0] sx, ax;

   assign sx = {{(AW-EW){disp[DW-1]}}, disp, {ALIGN{1'b0}}};

   if (ABS_SIGNED) begin : g_abs_sx
      assign ax = sx;
   end else begin : g_abs_zx
      assign ax = {{(AW-EW){1'b0}}, disp, {ALIGN{1'b0}}};
   end

   assign addr = abs_mode ? ax : (cia + sx);
endmodule

// File: rtl/brx_target.sv
module brx_target
   import brx_pkg::*;
#(
   parameter int AW         = 64,
   parameter int LONG_DW    = 24,
   parameter int SHORT_DW   = 14,
   parameter int ALIGN      = 2,
   parameter bit ABS_SIGNED = 1'b0
) (
   input  brx_form_e          form,
   input  logic [LONG_DW-1:0] disp,
   input  logic               abs_mode,
   input  logic [AW-1:0]      cia,
   input  logic [AW-1:0]      lr_cur,
   input  logic [AW-1:0]      ctr_cur,
   output logic [AW-1:0]      tgt
);
   localparam logic [AW-1:0] KEEP_MASK = {{(AW-ALIGN){1'b1}}, {ALIGN{1'b0}}};

   logic [AW-1:0] imm_addr [2];

   for (genvar g = 0; g < 2; g++) begin : g_imm
      localparam int DW = (g == 0) ? LONG_DW : SHORT_DW;
      brx_imm_ext #(
         .AW(AW), .DW(DW), .ALIGN(ALIGN), .ABS_SIGNED(ABS_SIGNED)
      ) u_ext (
         .disp(disp[DW-1:0]),
         .abs_mode(abs_mode),
         .cia(cia),
         .addr(imm_addr[g])
      );
   end

   always_comb begin
      unique case (form)
         FORM_IMM_LONG:  tgt = imm_addr[0];
         FORM_IMM_SHORT: tgt = imm_addr[1];
         FORM_VIA_LINK:  tgt = lr_cur & KEEP_MASK;
         default:        tgt = ctr_cur & KEEP_MASK;
      endcase
   end
endmodule

// File: rtl/brx_regs.sv
module brx_regs #(
   parameter int AW = 64
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          ld_lr_en,
   input  logic [AW-1:0] ld_lr_data,
   input  logic          ld_ctr_en,
   input  logic [AW-1:0] ld_ctr_data,
   input  logic          br_lr_en,
   input  logic [AW-1:0] br_lr_data,
   input  logic          br_ctr_en,
   input  logic [AW-1:0] br_ctr_data,
   output logic [AW-1:0] lr_q,
   output logic [AW-1:0] ctr_q
);
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         lr_q  <= '0;
         ctr_q <= '0;
      end else begin
         if (br_lr_en)       lr_q <= br_lr_data;
         else if (ld_lr_en)  lr_q <= ld_lr_data;
         if (br_ctr_en)      ctr_q <= br_ctr_data;
         else if (ld_ctr_en) ctr_q <= ld_ctr_data;
      end
   end
endmodule

// File: rtl/brx_resolve.sv
module brx_resolve
   import brx_pkg::*;
#(
   parameter int AW         = 64,
   parameter int CRW        = 32,
   parameter int LONG_DW    = 24,
   parameter int SHORT_DW   = 14,
   parameter int INSN_BYTES = 4,
   parameter bit ABS_SIGNED = 1'b0,
   localparam int SEL_W = $clog2(CRW),
   localparam int ALIGN = $clog2(INSN_BYTES)
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic               br_valid,
   input  logic [1:0]         br_form,
   input  logic [4:0]         br_rule,
   input  logic [SEL_W-1:0]   br_sel,
   input  logic [LONG_DW-1:0] br_disp,
   input  logic               br_abs,
   input  logic               br_link,
   input  logic [AW-1:0]      cia,
   input  logic [CRW-1:0]     cr,
   input  logic               lr_ld_en,
   input  logic [AW-1:0]      lr_ld_data,
   input  logic               ctr_ld_en,
   input  logic [AW-1:0]      ctr_ld_data,
   output logic               taken,
   output logic [AW-1:0]      target,
   output logic               illegal,
   output logic [AW-1:0]      lr_q,
   output logic [AW-1:0]      ctr_q
);
   if (CRW != (1 << SEL_W)) begin : g_bad_crw
      $error("CRW must be a power of two");
   end
   if (ALIGN < 1 || INSN_BYTES != (1 << ALIGN)) begin : g_bad_align
      $error("INSN_BYTES must be a power of two of at least 2");
   end
   if (SHORT_DW >= LONG_DW || AW <= LONG_DW + ALIGN) begin : g_bad_disp
      $error("displacement widths do not fit the address width");
   end

   brx_form_e     form;
   logic          take_ok, dec_req, legal, rule_hint_unused;
   logic [AW-1:0] ctr_next, tgt;

   assign form             = brx_form_e'(br_form);
   assign rule_hint_unused = br_rule[0];

   brx_decide #(.AW(AW), .CRW(CRW)) u_decide (
      .form(form),
      .rule(br_rule[RULE_W-1:1]),
      .sel(br_sel),
      .cr(cr),
      .ctr_cur(ctr_q),
      .take_ok(take_ok),
      .dec_req(dec_req),
      .ctr_next(ctr_next)
   );

   brx_target #(
      .AW(AW), .LONG_DW(LONG_DW), .SHORT_DW(SHORT_DW),
      .ALIGN(ALIGN), .ABS_SIGNED(ABS_SIGNED)
   ) u_target (
      .form(form),
      .disp(br_disp),
      .abs_mode(br_abs),
      .cia(cia),
      .lr_cur(lr_q),
      .ctr_cur(ctr_q),
      .tgt(tgt)
   );

   always_comb begin
      illegal = br_valid && (form == FORM_VIA_COUNT) && !br_rule[RB_NO_DEC];
      legal   = br_valid && !illegal;
      taken   = legal && take_ok;
      target  = legal ? tgt : '0;
   end

   brx_regs #(.AW(AW)) u_regs (
      .clk(clk),
      .rst_n(rst_n),
      .ld_lr_en(lr_ld_en),
      .ld_lr_data(lr_ld_data),
      .ld_ctr_en(ctr_ld_en),
      .ld_ctr_data(ctr_ld_data),
      .br_lr_en(legal && br_link),
      .br_lr_data(cia + AW'(INSN_BYTES)),
      .br_ctr_en(legal && dec_req),
      .br_ctr_data(ctr_next),
      .lr_q(lr_q),
      .ctr_q(ctr_q)
   );
endmodule

// File: rtl/brx_resolve_chk.sv
module brx_resolve_chk #(
   parameter int AW = 64
) (
   input logic          clk,
   input logic          rst_n,
   input logic          br_valid,
   input logic [1:0]    br_form,
   input logic [4:0]    br_rule,
   input logic          br_link,
   input logic [AW-1:0] cia,
   input logic          lr_ld_en,
   input logic          ctr_ld_en,
   input logic          taken,
   input logic [AW-1:0] target,
   input logic          illegal,
   input logic [AW-1:0] lr_q,
   input logic [AW-1:0] ctr_q
);
   AST_LONG_ALWAYS_TAKEN: assert property (@(posedge clk) disable iff (!rst_n)
      br_valid && br_form == 2'd0 |-> taken); // R4

   AST_REG_TARGET_ALIGNED: assert property (@(posedge clk) disable iff (!rst_n)
      br_valid && br_form[1] |-> target[1:0] == 2'b00); // R8

   AST_ILLEGAL_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
      illegal |-> !taken && target == '0); // R9

   AST_ILLEGAL_KEEPS_REGS: assert property (@(posedge clk) disable iff (!rst_n)
      illegal && !lr_ld_en && !ctr_ld_en |=> $stable(lr_q) && $stable(ctr_q)); // R9

   AST_LINK_RETURN: assert property (@(posedge clk) disable iff (!rst_n)
      br_valid && br_link && !illegal |=> lr_q == $past(cia) + AW'(4)); // R7

   AST_COUNT_DECREMENT: assert property (@(posedge clk) disable iff (!rst_n)
      br_valid && br_form != 2'd0 && !br_rule[2] && !illegal
      |=> ctr_q == $past(ctr_q) - AW'(1)); // R6

   AST_NO_DEC_HOLDS_COUNT: assert property (@(posedge clk) disable iff (!rst_n)
      br_valid && br_rule[2] && !ctr_ld_en |=> $stable(ctr_q)); // R3

   AST_IDLE_SILENT: assert property (@(posedge clk) disable iff (!rst_n)
      !br_valid |-> !taken && !illegal && target == '0); // R11
endmodule

bind brx_resolve brx_resolve_chk #(.AW(AW)) u_chk (
   .clk(clk), .rst_n(rst_n), .br_valid(br_valid), .br_form(br_form),
   .br_rule(br_rule), .br_link(br_link), .cia(cia), .lr_ld_en(lr_ld_en),
   .ctr_ld_en(ctr_ld_en), .taken(taken), .target(target), .illegal(illegal),
   .lr_q(lr_q), .ctr_q(ctr_q)
);

// File: tb/brx_resolve_test.sv
module brx_resolve_test;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        br_valid = 1'b0;
   logic [1:0]  br_form = '0;
   logic [4:0]  br_rule = '0;
   logic [4:0]  br_sel = '0;
   logic [23:0] br_disp = '0;
   logic        br_abs = 1'b0;
   logic        br_link = 1'b0;
   logic [63:0] cia = '0;
   logic [31:0] cr = '0;
   logic        lr_ld_en = 1'b0;
   logic [63:0] lr_ld_data = '0;
   logic        ctr_ld_en = 1'b0;
   logic [63:0] ctr_ld_data = '0;
   logic        taken, illegal;
   logic [63:0] target, lr_q, ctr_q;

   int n_checks = 0;
   int n_fail = 0;
   bit done = 1'b0;

   always #2.5 clk = ~clk;

   brx_resolve uut (.*);

   typedef struct packed {
      logic [1:0]  form;
      logic [4:0]  rule;
      logic [4:0]  sel;
      logic [23:0] disp;
      logic        ab;
      logic        lk;
      logic [63:0] pc;
      logic [31:0] crv;
      logic [63:0] lr0;
      logic [63:0] ctr0;
      logic        e_tk;
      logic [63:0] e_tgt;
      logic        e_ill;
      logic [63:0] e_lr;
      logic [63:0] e_ctr;
   } vec_t;

   localparam int NV = 18;
   localparam vec_t VECS [NV] = '{
      // R4 long relative, positive
      '{2'd0, 5'd0, 5'd0, 24'h000010, 1'b0, 1'b0, 64'h1000, 32'h0, 64'h500, 64'd7, 1'b1, 64'h1040, 1'b0, 64'h500, 64'd7},
      // R4 long relative, negative, with link (R7)
      '{2'd0, 5'd0, 5'd0, 24'hFFFFFF, 1'b0, 1'b1, 64'h2000, 32'h0, 64'h500, 64'd7, 1'b1, 64'h1FFC, 1'b0, 64'h2004, 64'd7},
      // R4 long absolute, zero-extended
      '{2'd0, 5'd0, 5'd0, 24'hFFFFFF, 1'b1, 1'b0, 64'h2000, 32'h0, 64'h500, 64'd7, 1'b1, 64'h3FFFFFC, 1'b0, 64'h500, 64'd7},
      // R2 rule 12, bit set
      '{2'd1, 5'd12, 5'd0, 24'h0008, 1'b0, 1'b0, 64'h3000, 32'h80000000, 64'h500, 64'd7, 1'b1, 64'h3020, 1'b0, 64'h500, 64'd7},
      // R2 rule 12, bit clear
      '{2'd1, 5'd12, 5'd0, 24'h0008, 1'b0, 1'b0, 64'h3000, 32'h7FFFFFFF, 64'h500, 64'd7, 1'b0, 64'h3020, 1'b0, 64'h500, 64'd7},
      // R5 rule 4, negative short displacement
      '{2'd1, 5'd4, 5'd10, 24'h3FFF, 1'b0, 1'b0, 64'h4000, 32'h0, 64'h500, 64'd7, 1'b1, 64'h3FFC, 1'b0, 64'h500, 64'd7},
      '{2'd1, 5'd4, 5'd10, 24'h3FFF, 1'b0, 1'b0, 64'h4000, 32'h00200000, 64'h500, 64'd7, 1'b0, 64'h3FFC, 1'b0, 64'h500, 64'd7},
      // R6 decrement to non-zero, R5 short absolute
      '{2'd1, 5'd16, 5'd0, 24'h2000, 1'b1, 1'b0, 64'h4000, 32'h0, 64'h500, 64'd2, 1'b1, 64'h8000, 1'b0, 64'h500, 64'd1},
      '{2'd1, 5'd16, 5'd0, 24'h2000, 1'b1, 1'b0, 64'h4000, 32'h0, 64'h500, 64'd1, 1'b0, 64'h8000, 1'b0, 64'h500, 64'd0},
      // R2 branch on zero after decrement
      '{2'd1, 5'd18, 5'd0, 24'h2000, 1'b1, 1'b0, 64'h4000, 32'h0, 64'h500, 64'd1, 1'b1, 64'h8000, 1'b0, 64'h500, 64'd0},
      // R2 rule 0: count non-zero and bit clear, with link
      '{2'd1, 5'd0, 5'd31, 24'h0004, 1'b0, 1'b1, 64'h6000, 32'h0, 64'h500, 64'd5, 1'b1, 64'h6010, 1'b0, 64'h6004, 64'd4},
      // R8 link target with link update reads old value
      '{2'd2, 5'd20, 5'd0, 24'h0, 1'b0, 1'b1, 64'h5000, 32'h0, 64'h12345677, 64'd7, 1'b1, 64'h12345674, 1'b0, 64'h5004, 64'd7},
      '{2'd2, 5'd12, 5'd3, 24'h0, 1'b0, 1'b0, 64'h5000, 32'h10000000, 64'h8000, 64'd7, 1'b1, 64'h8000, 1'b0, 64'h8000, 64'd7},
      // R8 count target
      '{2'd3, 5'd20, 5'd0, 24'h0, 1'b0, 1'b0, 64'h5000, 32'h0, 64'h500, 64'hABCD03, 1'b1, 64'hABCD00, 1'b0, 64'h500, 64'hABCD03},
      // R9 illegal
      '{2'd3, 5'd16, 5'd0, 24'h0, 1'b0, 1'b1, 64'h5000, 32'hFFFFFFFF, 64'h500, 64'd9, 1'b0, 64'h0, 1'b1, 64'h500, 64'd9},
      // R3 always-taken pattern, no decrement
      '{2'd1, 5'd23, 5'd0, 24'h0004, 1'b0, 1'b0, 64'h7000, 32'h0, 64'h500, 64'd0, 1'b1, 64'h7010, 1'b0, 64'h500, 64'd0},
      // R4 rule ignored on long form
      '{2'd0, 5'd0, 5'd0, 24'h000001, 1'b0, 1'b0, 64'h7000, 32'h0, 64'h500, 64'd3, 1'b1, 64'h7004, 1'b0, 64'h500, 64'd3},
      // R6 zero count wraps
      '{2'd1, 5'd16, 5'd0, 24'h0001, 1'b0, 1'b0, 64'h7000, 32'h0, 64'h500, 64'd0, 1'b1, 64'h7004, 1'b0, 64'h500, 64'hFFFFFFFFFFFFFFFF}
   };

   task automatic check(input string tag, input logic [63:0] act, input logic [63:0] exp);
      n_checks++;
      if (act !== exp) begin
         n_fail++;
         $display("FAIL %s: actual %h expected %h", tag, act, exp);
      end
   endtask

   task automatic finish_run();
      $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
      $finish;
   endtask

   task automatic load_regs(input logic [63:0] lv, input logic [63:0] cv);
      @(negedge clk);
      br_valid = 1'b0;
      lr_ld_en = 1'b1; lr_ld_data = lv;
      ctr_ld_en = 1'b1; ctr_ld_data = cv;
      @(negedge clk);
      lr_ld_en = 1'b0; ctr_ld_en = 1'b0;
   endtask

   task automatic drive(input logic [1:0] f, input logic [4:0] r, input logic [4:0] s,
                        input logic [23:0] d, input logic a, input logic l,
                        input logic [63:0] p, input logic [31:0] c);
      br_valid = 1'b1; br_form = f; br_rule = r; br_sel = s;
      br_disp = d; br_abs = a; br_link = l; cia = p; cr = c;
   endtask

   initial begin
      repeat (100000) @(posedge clk);
      if (!done) begin
         n_checks++; n_fail++;
         $display("FAIL watchdog: actual hung expected finish");
         finish_run();
      end
   end

   initial begin
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      #1;
      check("R11 reset lr", lr_q, 64'h0);
      check("R11 reset ctr", ctr_q, 64'h0);
      check("R11 idle taken", {63'b0, taken}, 64'h0);
      check("R11 idle illegal", {63'b0, illegal}, 64'h0);

      for (int i = 0; i < NV; i++) begin
         vec_t v;
         string ftag;
         v = VECS[i];
         case (v.form)
            2'd0: ftag = "R4";
            2'd1: ftag = "R5";
            2'd2: ftag = "R8";
            default: ftag = "R9";
         endcase
         load_regs(v.lr0, v.ctr0);
         drive(v.form, v.rule, v.sel, v.disp, v.ab, v.lk, v.pc, v.crv);
         #1;
         check($sformatf("R2 vec %0d taken", i), {63'b0, taken}, {63'b0, v.e_tk});
         check($sformatf("%s vec %0d target", ftag, i), target, v.e_tgt);
         check($sformatf("R9 vec %0d illegal", i), {63'b0, illegal}, {63'b0, v.e_ill});
         check($sformatf("R12 vec %0d lr before edge", i), lr_q, v.lr0);
         @(negedge clk);
         br_valid = 1'b0;
         #1;
         check($sformatf("R7 vec %0d lr", i), lr_q, v.e_lr);
         check($sformatf("R6 vec %0d ctr", i), ctr_q, v.e_ctr);
      end

      // R1: each selector picks the matching condition bit
      for (int k = 0; k < 32; k++) begin
         @(negedge clk);
         drive(2'd1, 5'd12, 5'(k), 24'h0, 1'b0, 1'b0, 64'h100, 32'h80000000 >> k);
         #1;
         check($sformatf("R1 selector %0d set", k), {63'b0, taken}, 64'h1);
         cr = ~(32'h80000000 >> k);
         #1;
         check($sformatf("R1 selector %0d clear", k), {63'b0, taken}, 64'h0);
      end
      @(negedge clk);
      br_valid = 1'b0;

      // R10: load alone, then branch beats same-cycle load
      load_regs(64'h1111, 64'd3);
      #1;
      check("R10 load lr", lr_q, 64'h1111);
      check("R10 load ctr", ctr_q, 64'd3);
      drive(2'd1, 5'd16, 5'd0, 24'h0, 1'b0, 1'b1, 64'h9000, 32'h0);
      lr_ld_en = 1'b1; lr_ld_data = 64'hDEAD;
      ctr_ld_en = 1'b1; ctr_ld_data = 64'h50;
      @(negedge clk);
      br_valid = 1'b0; lr_ld_en = 1'b0; ctr_ld_en = 1'b0;
      #1;
      check("R10 branch wins lr", lr_q, 64'h9004);
      check("R10 branch wins ctr", ctr_q, 64'd2);

      // R11: a linked, decrementing branch held invalid changes nothing
      br_form = 2'd1; br_rule = 5'd16; br_link = 1'b1; cia = 64'hA000;
      @(negedge clk);
      #1;
      check("R11 invalid lr kept", lr_q, 64'h9004);
      check("R11 invalid ctr kept", ctr_q, 64'd2);
      check("R11 invalid target", target, 64'h0);

      done = 1'b1;
      finish_run();
   end
endmodule